// File: doc/BRIEF.md
# Programmable Down-Counter Timer

This block is a single memory-mapped timer whose counter steps down by one on each count pulse. It has a small register file addressed by word offset. Through that file the host programs a reload value, chooses one of three counting modes (free-running, periodic, one-shot), chooses a 16-bit or 32-bit counter and chooses a tick divider of 1, 16 or 256. It then watches the raw and masked interrupt status and acknowledges an expiry by writing the clear offset.

Two registers hold the reload value, and they differ in when the value takes effect. A write to the primary load offset restarts the count at once. A write to the background offset only changes the value used at the next reload, so a running period finishes undisturbed. The `tick` input is an enable for the prescaler. The interrupt is a level output that stays high until software clears it.

Top module: `dcnt_timer`

## Requirements
- R1: After reset, control reads 0x20 (interrupt enable set, timer stopped). The current value and the load value read 0, and `irq` is low.
- R2: Word offsets are: 0 load, 1 current value, 2 control, 3 interrupt clear, 4 raw status (bit 0), 5 masked status (bit 0), 6 background load. Offsets 3 and 7 read 0. Writes to offset 1 and offset 7 change nothing.
- R3: A write to offset 0 stores the value and, in the same edge, reloads the counter with the mode's limit. The limit is the stored value in periodic or one-shot mode, and all ones in free-running mode.
- R4: A write to offset 6 stores the value, and reading either offset 0 or offset 6 returns it. The running count is untouched, and the counter takes the new value at its next reload.
- R5: Control bits: 0 one-shot, 1 32-bit width, 3:2 divider, 5 interrupt enable, 6 periodic, 7 enable. In periodic mode the counter drops by one per count pulse. The pulse that finds it at zero is the expiry; that pulse reloads the load value, so the period is load+1 pulses.
- R6: In one-shot mode the expiry leaves the counter at zero and stopped. No further expiry occurs until a load write, or a control write with the enable bit set.
- R7: When bits 6 and 0 are both clear, the counter runs free. It wraps to 0xFFFF in 16-bit mode or to 0xFFFFFFFF in 32-bit mode. In 16-bit mode only the low 16 bits count and are read back.
- R8: A control write pauses counting for that cycle. If the new value has bit 7 set, the counter reloads with the new mode's limit. Otherwise it holds its value, and a stopped timer keeps it.
- R9: The divider counts `tick` cycles and issues one count pulse per 1 (bits 3:2 = 00 or 11), 16 (01) or 256 (10) ticks. With `tick` low the count does not move.
- R10: An expiry sets the raw flag. The flag stays set until any write to offset 3, and an expiry in the same cycle as the clear wins.
- R11: `irq` is high exactly when the raw flag and control bit 5 are both set. Offset 5 reads 0 while bit 5 is clear, while offset 4 still shows the raw flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable feeding the prescaler |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (3) | Word offset for reads and writes |
| wr_data | input | DATA_W (32) | Write data |
| rd_data | output | DATA_W (32) | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt, raw flag gated by enable |

## Verification
On every cycle the assertions check several properties. The interrupt output never rises while interrupt enable is clear. A load write in a reloading 32-bit mode puts the written value in the counter. The raw flag stays set until a clear and drops after a clear that has no expiry beside it. A stopped one-shot counter and a stopped counter under a background write keep their value. A periodic expiry reloads the load value. Only the bench scenarios can show the full timing: period lengths, the wrap of the free-running count from all ones, the divider pacing measured against real ticks, and the effect of offsets that are unknown or read-only.

// File: rtl/dcnt_timer_pkg.sv
package dcnt_timer_pkg;

    localparam int CTRL_W     = 8;
    localparam int OFS_LOAD   = 0;
    localparam int OFS_VALUE  = 1;
    localparam int OFS_CTRL   = 2;
    localparam int OFS_ICLR   = 3;
    localparam int OFS_RAW    = 4;
    localparam int OFS_MASKED = 5;
    localparam int OFS_BGLOAD = 6;

    // Field positions are decoded by software; MSB first.
    typedef struct packed {
        logic       enable;    // bit 7
        logic       periodic;  // bit 6
        logic       ie;        // bit 5
        logic       spare;     // bit 4
        logic [1:0] pscale;    // bits 3:2
        logic       wide;      // bit 1
        logic       oneshot;   // bit 0
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{enable: 1'b0, periodic: 1'b0, ie: 1'b1,
                                     spare: 1'b0, pscale: 2'b00, wide: 1'b0,
                                     oneshot: 1'b0};

endpackage

// File: rtl/dcnt_prescale.sv
module dcnt_prescale #(
    parameter int PRE_W     = 8,
    parameter int PRE_MID_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] sel,
    output logic       pulse
);
    logic [PRE_W-1:0] div_d, div_q;

    always_comb begin
        div_d = div_q + (tick ? PRE_W'(1) : PRE_W'(0));
        case (sel)
            2'b01:   pulse = tick && (&div_q[PRE_MID_W-1:0]);
            2'b10:   pulse = tick && (&div_q);
            default: pulse = tick;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end
endmodule

// File: rtl/dcnt_regs.sv
module dcnt_regs
    import dcnt_timer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] cnt_view,
    input  logic              raw,
    output ctrl_t             ctrl_q,
    output ctrl_t             ctrl_nx,
    output logic [DATA_W-1:0] load_nx,
    output logic              load_wr,
    output logic              ctrl_wr,
    output logic              clr_wr,
    output logic [DATA_W-1:0] rd_data
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic [DATA_W-1:0] load;
    } regs_s;

    regs_s r_d, r_q;
    logic  bg_wr;

    always_comb begin
        load_wr = wr_en && (addr == ADDR_W'(OFS_LOAD));
        bg_wr   = wr_en && (addr == ADDR_W'(OFS_BGLOAD));
        ctrl_wr = wr_en && (addr == ADDR_W'(OFS_CTRL));
        clr_wr  = wr_en && (addr == ADDR_W'(OFS_ICLR));

        r_d = r_q;
        if (load_wr || bg_wr) r_d.load = wr_data;
        if (ctrl_wr)          r_d.ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);

        rd_data = '0;
        case (addr)
            ADDR_W'(OFS_LOAD),
            ADDR_W'(OFS_BGLOAD): rd_data = r_q.load;
            ADDR_W'(OFS_VALUE):  rd_data = cnt_view;
            ADDR_W'(OFS_CTRL):   rd_data = DATA_W'(r_q.ctrl);
            ADDR_W'(OFS_RAW):    rd_data = DATA_W'(raw);
            ADDR_W'(OFS_MASKED): rd_data = DATA_W'(raw && r_q.ctrl.ie);
            default:             rd_data = '0;
        endcase
    end

    assign ctrl_q  = r_q.ctrl;
    assign ctrl_nx = r_d.ctrl;
    assign load_nx = r_d.load;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.ctrl <= CTRL_RESET;
            r_q.load <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/dcnt_core.sv
module dcnt_core
    import dcnt_timer_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_pulse,
    input  ctrl_t             ctrl_q,
    input  ctrl_t             ctrl_nx,
    input  logic [DATA_W-1:0] load_nx,
    input  logic              load_wr,
    input  logic              ctrl_wr,
    input  logic              clr_wr,
    output logic [DATA_W-1:0] cnt_view,
    output logic              raw,
    output logic              expire,
    output logic              stopped
);
    localparam logic [DATA_W-1:0] NARROW_ONES = DATA_W'({NARROW_W{1'b1}});

    typedef struct packed {
        logic [DATA_W-1:0] cnt;
        logic              raw;
        logic              stopped;
    } core_s;

    core_s c_d, c_q;

    function automatic logic [DATA_W-1:0] limit_of(ctrl_t c, logic [DATA_W-1:0] ld);
        if (c.periodic || c.oneshot) return ld;
        else if (c.wide)             return '1;
        else                         return NARROW_ONES;
    endfunction

    always_comb begin
        cnt_view = ctrl_q.wide ? c_q.cnt : (c_q.cnt & NARROW_ONES);
        c_d      = c_q;
        expire   = 1'b0;

        if (load_wr) begin
            c_d.cnt     = limit_of(ctrl_nx, load_nx);
            c_d.stopped = 1'b0;
        end else if (ctrl_wr) begin
            if (ctrl_nx.enable) begin
                c_d.cnt     = limit_of(ctrl_nx, load_nx);
                c_d.stopped = 1'b0;
            end
        end else if (ctrl_q.enable && cnt_pulse && !c_q.stopped) begin
            if (cnt_view == '0) begin
                expire = 1'b1;
                if (ctrl_q.oneshot) c_d.stopped = 1'b1;
                else                c_d.cnt     = limit_of(ctrl_q, load_nx);
            end else begin
                c_d.cnt = cnt_view - DATA_W'(1);
            end
        end

        if (clr_wr) c_d.raw = 1'b0;
        if (expire) c_d.raw = 1'b1;
    end

    assign raw     = c_q.raw;
    assign stopped = c_q.stopped;

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end
endmodule

// File: rtl/dcnt_timer.sv
module dcnt_timer
    import dcnt_timer_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 3,
    parameter int NARROW_W  = 16,
    parameter int PRE_W     = 8,
    parameter int PRE_MID_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    ctrl_t             ctrl_q, ctrl_nx;
    logic [DATA_W-1:0] load_nx, cnt_view;
    logic              load_wr, ctrl_wr, clr_wr;
    logic              cnt_pulse, raw, expire, stopped;

    dcnt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .cnt_view(cnt_view), .raw(raw),
        .ctrl_q(ctrl_q), .ctrl_nx(ctrl_nx), .load_nx(load_nx),
        .load_wr(load_wr), .ctrl_wr(ctrl_wr), .clr_wr(clr_wr),
        .rd_data(rd_data)
    );

    dcnt_prescale #(.PRE_W(PRE_W), .PRE_MID_W(PRE_MID_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sel(ctrl_q.pscale),
        .pulse(cnt_pulse)
    );

    dcnt_core #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_core (
        .clk(clk), .rst_n(rst_n), .cnt_pulse(cnt_pulse),
        .ctrl_q(ctrl_q), .ctrl_nx(ctrl_nx), .load_nx(load_nx),
        .load_wr(load_wr), .ctrl_wr(ctrl_wr), .clr_wr(clr_wr),
        .cnt_view(cnt_view), .raw(raw), .expire(expire), .stopped(stopped)
    );

    assign irq = raw && ctrl_q.ie;
endmodule

// File: rtl/dcnt_timer_chk.sv
module dcnt_timer_chk
    import dcnt_timer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [CTRL_W-1:0] ctrl,
    input logic [DATA_W-1:0] load,
    input logic [DATA_W-1:0] cnt_view,
    input logic              raw,
    input logic              expire,
    input logic              stopped,
    input logic              irq
);
    logic clr_hit, ld_hit, bg_hit, ctl_hit;
    assign clr_hit = wr_en && (addr == ADDR_W'(OFS_ICLR));
    assign ld_hit  = wr_en && (addr == ADDR_W'(OFS_LOAD));
    assign bg_hit  = wr_en && (addr == ADDR_W'(OFS_BGLOAD));
    assign ctl_hit = wr_en && (addr == ADDR_W'(OFS_CTRL));

    p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[5] |-> !irq);

    p_load_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ld_hit && (ctrl[6] || ctrl[0]) && ctrl[1] |=> cnt_view == $past(wr_data));

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit && !expire |=> !raw);

    p_raw_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        raw && !clr_hit |=> raw);

    p_oneshot_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stopped && !ld_hit && !ctl_hit |=> $stable(cnt_view));

    p_bg_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bg_hit && !ctrl[7] |=> $stable(cnt_view));

    p_periodic_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        expire && ctrl[6] && !ctrl[0] && ctrl[1] && !wr_en |=> cnt_view == $past(load));
endmodule

bind dcnt_timer dcnt_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .ctrl(ctrl_q), .load(load_nx), .cnt_view(cnt_view), .raw(raw),
    .expire(expire), .stopped(stopped), .irq(irq)
);

// File: tb/dcnt_timer_bench.sv
`timescale 1ns/1ps
module dcnt_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    dcnt_timer u_dcnt_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        addr = 3'(a); wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        addr = 3'(a);
        #0.1;
        d = rd_data;
    endtask

    task automatic chk_rd(input string req, input int a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        chk_rd("R1 ctrl", 2, 32'h20);
        chk_rd("R1 value", 1, 0);
        chk_rd("R1 load", 0, 0);
        chk_rd("R1 raw", 4, 0);
        check("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_periodic();
        wr(0, 5);
        chk_rd("R3 free-running limit on load write", 1, 32'hFFFF);
        wr(2, 32'hE2);
        chk_rd("R8 reload on enable", 1, 5);
        wait_clk(5);
        chk_rd("R5 reaches zero", 1, 0);
        chk_rd("R10 raw before expiry", 4, 0);
        wait_clk(1);
        chk_rd("R10 raw on expiry", 4, 1);
        chk_rd("R5 reload after expiry", 1, 5);
        chk_rd("R11 masked set", 5, 1);
        check("R11 irq high", 32'(irq), 1);
        wr(3, 32'hDEAD);
        chk_rd("R10 cleared", 4, 0);
        check("R11 irq low after clear", 32'(irq), 0);
        chk_rd("R5 count during clear", 1, 4);
        wait_clk(5);
        chk_rd("R5 second period", 4, 1);
    endtask

    task automatic t_masked();
        logic [31:0] v;
        wr(2, 32'h42);
        chk_rd("R11 raw kept", 4, 1);
        chk_rd("R11 masked zero", 5, 0);
        check("R11 irq masked", 32'(irq), 0);
        rd(1, v);
        wait_clk(3);
        chk_rd("R8 disabled holds", 1, v);
    endtask

    task automatic t_tick_gate();
        wr(3, 0);
        wr(2, 32'hE2);
        tick = 1'b0;
        wait_clk(3);
        chk_rd("R9 tick low holds", 1, 5);
        tick = 1'b1;
        wait_clk(1);
        chk_rd("R9 tick resumes", 1, 4);
    endtask

    task automatic t_oneshot();
        wr(3, 0);
        wr(0, 3);
        wr(2, 32'hA3);
        chk_rd("R6 start", 1, 3);
        wait_clk(3);
        chk_rd("R6 zero", 1, 0);
        wait_clk(1);
        chk_rd("R6 expiry raw", 4, 1);
        chk_rd("R6 stays zero", 1, 0);
        wr(3, 0);
        wait_clk(10);
        chk_rd("R6 no re-expiry", 4, 0);
        chk_rd("R6 still zero", 1, 0);
        wr(2, 32'hA3);
        chk_rd("R6 restart", 1, 3);
    endtask

    task automatic t_free();
        wr(3, 0);
        wr(2, 32'hA0);
        chk_rd("R7 16-bit start", 1, 32'hFFFF);
        wait_clk(32'hFFFF);
        chk_rd("R7 16-bit zero", 1, 0);
        chk_rd("R7 no raw yet", 4, 0);
        wait_clk(1);
        chk_rd("R7 16-bit wrap", 1, 32'hFFFF);
        chk_rd("R7 wrap raw", 4, 1);
        wr(2, 32'hA2);
        chk_rd("R7 32-bit start", 1, 32'hFFFF_FFFF);
        wait_clk(1);
        chk_rd("R7 32-bit step", 1, 32'hFFFF_FFFE);
    endtask

    task automatic t_bgload();
        wr(0, 10);
        wr(3, 0);
        wr(2, 32'hE2);
        chk_rd("R4 start", 1, 10);
        wait_clk(3);
        wr(6, 2);
        chk_rd("R4 count untouched", 1, 6);
        chk_rd("R4 read load", 0, 2);
        chk_rd("R4 read bg", 6, 2);
        wait_clk(6);
        chk_rd("R4 zero", 1, 0);
        wait_clk(1);
        chk_rd("R4 next reload uses bg", 1, 2);
        chk_rd("R4 expiry", 4, 1);
        wr(0, 100);
        chk_rd("R3 immediate reload", 1, 100);
    endtask

    task automatic t_divider(input logic [31:0] ctl, input int div, input string req);
        logic [31:0] v0, v1;
        wr(0, 1000);
        wr(2, ctl);
        rd(1, v0);
        for (int i = 0; i < 300; i++) begin
            rd(1, v1);
            if (v1 != v0) break;
            @(negedge clk);
        end
        rd(1, v1);
        wait_clk(div - 1);
        chk_rd(req, 1, v1);
        wait_clk(1);
        chk_rd(req, 1, v1 - 1);
    endtask

    task automatic t_prescale();
        t_divider(32'hE6, 16, "R9 divide by 16");
        t_divider(32'hEA, 256, "R9 divide by 256");
        wr(2, 32'hEE);
        chk_rd("R9 code 11 start", 1, 1000);
        wait_clk(1);
        chk_rd("R9 code 11 divides by 1", 1, 999);
    endtask

    task automatic t_offsets();
        logic [31:0] v;
        wr(2, 32'h20);
        rd(1, v);
        wr(1, 32'h1234);
        chk_rd("R2 value read-only", 1, v);
        wr(7, 32'hFFFF_FFFF);
        chk_rd("R2 unknown reads zero", 7, 0);
        chk_rd("R2 clear offset reads zero", 3, 0);
        chk_rd("R2 load kept", 0, 1000);
        chk_rd("R2 ctrl kept", 2, 32'h20);
        chk_rd("R2 value kept", 1, v);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        wait_clk(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_periodic();
        t_masked();
        t_tick_gate();
        t_oneshot();
        t_free();
        t_bgload();
        t_prescale();
        t_offsets();
        finish_run();
    end

    initial begin
        #(200000 * 5.0);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule